// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is the arithmetic logic unit of a small processor datapath. It receives two operand words and a two-bit operation code. It returns a result word and three condition flags: signed overflow, zero and carry/borrow. The block supports exactly four operations. Two are arithmetic: add, and a subtract that takes the first operand away from the second. Two are bitwise: AND and XOR.

The unit is purely combinational. It has no clock and no storage, so its outputs settle within the same cycle as its inputs. Whether the flags are captured into a condition register, and when, is decided by the surrounding datapath. The operand width is a parameter.

Top module: `cc_alu`

## Requirements
- R1: With `op_i` = 0, `result_o` is `a_i + b_i` modulo 2^WIDTH.
- R2: With `op_i` = 1, `result_o` is `b_i - a_i` modulo 2^WIDTH. The second operand is the minuend.
- R3: With `op_i` = 2, `result_o` is the bitwise AND of `a_i` and `b_i`.
- R4: With `op_i` = 3, `result_o` is the bitwise XOR of `a_i` and `b_i`.
- R5: `zf_o` is 1 exactly when every bit of `result_o` is 0, for all four operations.
- R6: For add, `of_o` is 1 exactly when both operands have equal sign bits and the result's sign bit differs from them.
- R7: For subtract, `of_o` is 1 exactly when `b_i` and `a_i` have different sign bits and the result's sign bit differs from that of `b_i`.
- R8: For add, `cf_o` is the carry out of the most significant bit. This is 1 when the unsigned sum exceeds 2^WIDTH-1.
- R9: For subtract, `cf_o` is the borrow. This is 1 exactly when `b_i` is less than `a_i` as unsigned numbers.
- R10: For AND and XOR, both `of_o` and `cf_o` are 0.
- R11: All outputs follow the inputs combinationally. A change on the inputs is visible on the outputs with no clock edge in between.
- R12: WIDTH defaults to 32 bits, and the corner values of a 32-bit word behave as in R1, R2, R5, R6, R8 and R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand; the subtrahend for subtract |
| b_i | input | WIDTH | Second operand; the minuend for subtract |
| op_i | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| result_o | output | WIDTH | Operation result |
| of_o | output | 1 | Signed overflow flag |
| zf_o | output | 1 | Zero-result flag |
| cf_o | output | 1 | Carry (add) or borrow (subtract) flag |

## Verification
Overflow, carry and zero can all be raised by a single arithmetic operation. Adding the most negative value to itself wraps the result to zero, which sets OF, CF and ZF together. Subtracting equal operands gives zero with no borrow. The bench reaches every such coincidence by sweeping all operand pairs and all four operations on a 4-bit instance. For each vector it derives all four outputs from signed and unsigned integer arithmetic, and each output is judged on its own against that reference. This means a flag that is correct alone but wrong when it coincides with another flag is still reported.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic carry;
  } alu_flags_t;
endpackage

// File: rtl/cc_alu_addsub.sv
// Ripple adder shared by add and subtract; subtract computes b + ~a + 1.
module cc_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opnd;
  logic [WIDTH:0]   carry;

  assign opnd     = sub_i ? ~a_i : a_i;
  assign carry[0] = sub_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]   = b_i[i] ^ opnd[i] ^ carry[i];
    assign carry[i+1] = (b_i[i] & opnd[i]) | (carry[i] & (b_i[i] ^ opnd[i]));
  end

  assign cout_o = carry[WIDTH];
  // Same-sign addends with a sign flip in the sum.
  assign ovf_o  = (b_i[MSB] == opnd[MSB]) && (sum_o[MSB] != b_i[MSB]);
endmodule

// File: rtl/cc_alu_bitwise.sv
module cc_alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_xor_i,
  output logic [WIDTH-1:0] res_o
);
  assign res_o = sel_xor_i ? (a_i ^ b_i) : (a_i & b_i);
endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  output alu_flags_t       flags_o
);
  always_comb begin
    flags_o.zero = ~|res_i;
    unique case (op_i)
      OP_ADD: begin flags_o.ovf = ovf_i; flags_o.carry = cout_i;  end
      OP_SUB: begin flags_o.ovf = ovf_i; flags_o.carry = ~cout_i; end
      default: begin flags_o.ovf = 1'b0; flags_o.carry = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             of_o,
  output logic             zf_o,
  output logic             cf_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             arith_cout;
  logic             arith_ovf;
  alu_flags_t       flags;

  assign op = alu_op_e'(op_i);

  cc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op == OP_SUB),
    .sum_o (arith_res),
    .cout_o(arith_cout),
    .ovf_o (arith_ovf)
  );

  cc_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_xor_i(op == OP_XOR),
    .res_o    (logic_res)
  );

  // op_i[1] splits arithmetic from bitwise group.
  assign result_o = op_i[1] ? logic_res : arith_res;

  cc_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .op_i   (op),
    .res_i  (result_o),
    .cout_i (arith_cout),
    .ovf_i  (arith_ovf),
    .flags_o(flags)
  );

  assign of_o = flags.ovf;
  assign zf_o = flags.zero;
  assign cf_o = flags.carry;
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             of_o,
  input logic             zf_o,
  input logic             cf_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i, result_o, of_o, zf_o, cf_o})) begin
      assert_zero_flag_R5: assert (zf_o == (result_o == '0));
      if (op_i == 2'd0) begin
        assert_add_value_R1: assert ((result_o - b_i) == a_i);
        assert_add_carry_R8: assert (cf_o == (result_o < a_i));
        assert_add_ovf_R6: assert (of_o ==
          (($signed(a_i) >= 0 && $signed(b_i) >= 0 && $signed(result_o) < 0) ||
           ($signed(a_i) < 0 && $signed(b_i) < 0 && $signed(result_o) >= 0)));
      end
      if (op_i == 2'd1) begin
        assert_sub_value_R2: assert ((result_o + a_i) == b_i);
        assert_sub_borrow_R9: assert (cf_o == (b_i < a_i));
        assert_sub_ovf_R7: assert (of_o ==
          (($signed(b_i) >= 0 && $signed(a_i) < 0 && $signed(result_o) < 0) ||
           ($signed(b_i) < 0 && $signed(a_i) >= 0 && $signed(result_o) >= 0)));
      end
      if (op_i == 2'd2) begin
        assert_and_value_R3: assert (((result_o & ~a_i) == '0) &&
                                     ((result_o & ~b_i) == '0) &&
                                     ((a_i & b_i & ~result_o) == '0));
      end
      if (op_i == 2'd3) begin
        assert_xor_value_R4: assert ((result_o ^ b_i) == a_i);
      end
      if (op_i[1]) begin
        assert_no_logic_flags_R10: assert (!of_o && !cf_o);
      end
    end
  end
endmodule

bind cc_alu cc_alu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/cc_alu_tb_top.sv
`timescale 1ns/1ps
module cc_alu_tb_top;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0;
  int n_errors = 0;

  logic [SW-1:0] a, b;
  logic [1:0]    op;
  logic [SW-1:0] res;
  logic          of, zf, cf;

  cc_alu #(.WIDTH(SW)) dut_i (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .of_o(of), .zf_o(zf), .cf_o(cf)
  );

  logic [31:0] wa, wb;
  logic [1:0]  wop;
  logic [31:0] wres;
  logic        wof, wzf, wcf;

  cc_alu dut_wide_i (
    .a_i(wa), .b_i(wb), .op_i(wop),
    .result_o(wres), .of_o(wof), .zf_o(wzf), .cf_o(wcf)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s act=%0h exp=%0h (a=%0h b=%0h op=%0d)", tag, act, exp, a, b, op);
    end
  endtask

  task automatic judge_small();
    int ua, ub, sa, sb, full, sr, eres;
    bit ecf, eof, ezf;
    ua = int'(a); ub = int'(b);
    sa = (ua >= 8) ? ua - 16 : ua;
    sb = (ub >= 8) ? ub - 16 : ub;
    eof = 0; ecf = 0;
    case (op)
      2'd0: begin
        full = ua + ub; eres = full % 16; ecf = (full > 15);
        sr = sa + sb; eof = (sr > 7) || (sr < -8);
        check(int'(res) == eres, "R1 sum", res, eres);
        check(of == eof, "R6 add overflow", of, eof);
        check(cf == ecf, "R8 add carry", cf, ecf);
      end
      2'd1: begin
        full = ub - ua; eres = (full + 16) % 16; ecf = (full < 0);
        sr = sb - sa; eof = (sr > 7) || (sr < -8);
        check(int'(res) == eres, "R2 difference", res, eres);
        check(of == eof, "R7 sub overflow", of, eof);
        check(cf == ecf, "R9 sub borrow", cf, ecf);
      end
      2'd2: begin
        eres = ua & ub;
        check(int'(res) == eres, "R3 and", res, eres);
        check(!of && !cf, "R10 and flags", {of, cf}, 0);
      end
      default: begin
        eres = ua ^ ub;
        check(int'(res) == eres, "R4 xor", res, eres);
        check(!of && !cf, "R10 xor flags", {of, cf}, 0);
      end
    endcase
    ezf = (eres == 0);
    check(zf == ezf, "R5 zero flag", zf, ezf);
  endtask

  task automatic wide(input logic [31:0] x, input logic [31:0] y, input logic [1:0] o,
                      input logic [31:0] er, input bit eo, input bit ez, input bit ec);
    @(posedge clk);
    wa = x; wb = y; wop = o;
    @(negedge clk);
    check(wres == er, "R12 wide result", wres, er);
    check({wof, wzf, wcf} == {eo, ez, ec}, "R12 wide flags", {wof, wzf, wcf}, {eo, ez, ec});
  endtask

  initial begin
    a = '0; b = '0; op = 2'd0;
    wa = '0; wb = '0; wop = 2'd0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // Idle state: zero inputs give zero sum with only ZF set (R1, R5)
    check(res == '0 && {of, zf, cf} == 3'b010, "R1 R5 idle", {res, of, zf, cf}, 3'b010);

    // Exhaustive sweep of the 4-bit instance
    for (int o = 0; o < 4; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          @(posedge clk);
          a = SW'(x); b = SW'(y); op = 2'(o);
          @(negedge clk);
          judge_small();
        end
      end
    end

    // R11: change inputs between edges, sample before the next edge
    @(negedge clk);
    #2; a = 4'd3; b = 4'd5; op = 2'd1;
    #1; check(res == 4'd2 && !cf, "R11 comb follow", res, 2);
    #2; a = 4'd6; op = 2'd3;
    #1; check(res == 4'd3 && !zf, "R11 comb follow", res, 3);

    // R12: default width and 32-bit corners
    check($bits(wres) == 32, "R12 default width", $bits(wres), 32);
    wide(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 32'h8000_0000, 1, 0, 0);
    wide(32'hFFFF_FFFF, 32'h0000_0001, 2'd0, 32'h0000_0000, 0, 1, 1);
    wide(32'h8000_0000, 32'h8000_0000, 2'd0, 32'h0000_0000, 1, 1, 1);
    wide(32'h0000_0001, 32'h0000_0000, 2'd1, 32'hFFFF_FFFF, 0, 0, 1);
    wide(32'h0000_0001, 32'h8000_0000, 2'd1, 32'h7FFF_FFFF, 1, 0, 0);
    wide(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd1, 32'h0000_0000, 0, 1, 0);
    wide(32'hF0F0_F0F0, 32'hFF00_FF00, 2'd2, 32'hF000_F000, 0, 0, 0);
    wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 32'h0000_0000, 0, 1, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule